// File: doc/BRIEF.md
# Largest-Deficit Head-Cache Refill Scheduler

This block schedules refills of the per-queue SRAM head caches on the egress side of a hybrid packet buffer. Most of each FIFO queue sits in a large, slow DRAM, and only the few cells nearest each queue's head sit in SRAM. For every queue the block keeps two counts: cells cached in SRAM (the occupancy) and cells still waiting in DRAM. An outside arbiter sends read grants in an order nobody can predict. Each grant takes one cell from a queue's SRAM. An enqueue strobe records a cell written to a queue's DRAM region.

Once every `BLK` cycles a refill slot opens. A queue is eligible when it has cells in DRAM and its occupancy is below the threshold `HEAD_THRESH`. Its deficit is the threshold minus its occupancy, and the deficit of any other queue counts as zero. The eligible queue with the largest deficit gets the slot, with ties going to the lowest index. The block then issues a one-cycle DRAM request that names the queue and the number of cells: `BLK`, or fewer when DRAM holds fewer. The DRAM count drops at once, and the occupancy rises by the same amount `XFER_LAT` cycles later, when the transfer lands. Always serving the worst-off queue keeps every head cache within about b(2+ln Q) cells, and no cell needs to wait for its grant.

A two-state machine sequences the slots. In `ST_IDLE` it waits for the slot tick. The transition *launch* (slot tick with an eligible queue) issues the request and enters `ST_XFER`. In `ST_XFER` a latency counter runs down, and the transition *land* (counter at zero) adds the cells to the queue's occupancy and returns to `ST_IDLE`. A slot tick with no eligible queue leaves the machine in `ST_IDLE`. `XFER_LAT` must lie between 1 and `BLK`.

Top module: `hcache_refill_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `req_valid` and `underflow` are 0, and every occupancy and DRAM count is zero.
- R2: An enqueue strobe raises the DRAM count of queue `enq_queue` by one. A cell counted this way is later offered in a refill request for that queue.
- R3: Slot ticks fall on the first clock edge after reset and on every `BLK`-th edge after it. `req_valid` can only rise one cycle after a slot tick and stays high for exactly one cycle.
- R4: The queue granted a slot is the eligible queue with the largest deficit, `HEAD_THRESH - occupancy`. A queue is eligible when its DRAM count is non-zero and its occupancy is below `HEAD_THRESH`.
- R5: When several eligible queues share the largest deficit, the one with the lowest index is served.
- R6: No request is issued at a slot tick when no queue is eligible, whether because no queue holds cells in DRAM or because every such queue is at or above the threshold.
- R7: `req_cells` equals the smaller of `BLK` and the served queue's DRAM count. That queue's DRAM count drops by the same amount on the launch edge.
- R8: The served queue's occupancy rises by `req_cells` on the clock edge `XFER_LAT` cycles after the launch edge. No other request is launched before that edge.
- R9: A grant to a queue with non-zero occupancy removes one cell. A grant to a queue with zero occupancy leaves the occupancy unchanged and sets `underflow` on that edge.
- R10: Once set, `underflow` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gnt_valid | input | 1 | Read grant strobe from the arbiter |
| gnt_queue | input | QW | Queue the grant is for |
| enq_valid | input | 1 | A cell was written to a queue's DRAM region |
| enq_queue | input | QW | Queue receiving the DRAM cell |
| req_valid | output | 1 | One-cycle DRAM refill request |
| req_queue | output | QW | Queue to refill |
| req_cells | output | CW | Cells to move, 1 to BLK |
| underflow | output | 1 | Sticky flag: a grant found an empty head cache |

## Verification
The properties assume the enqueue strobes never push a DRAM count past its width and that `XFER_LAT` is no larger than `BLK`. The cell-conservation property also takes every enqueue to be a real cell that a later request accounts for. The bench keeps each queue's DRAM backlog to a few dozen cells. Outside one deliberate late test, it grants only queues that its own model shows as holding cells. That deliberate test aims a single grant at an empty queue after a full drain, which exercises the underflow flag and its stickiness.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    // Refill sequencer states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,   // waiting for the next refill slot
        ST_XFER = 1'b1    // a block of cells is in flight from DRAM
    } refill_state_e;

endpackage

// File: rtl/hcr_queue_ctr.sv
module hcr_queue_ctr #(
    parameter int OW     = 5,
    parameter int DRAM_W = 16,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_i,
    input  logic              grant_i,
    input  logic              take_i,
    input  logic [CW-1:0]     take_cells_i,
    input  logic              land_i,
    input  logic [CW-1:0]     land_cells_i,
    output logic [OW-1:0]     occ_o,
    output logic [DRAM_W-1:0] dram_o,
    output logic              grant_miss_o
);

    logic [OW-1:0]     occ_d;
    logic [DRAM_W-1:0] dram_d;

    // a grant against an empty head cache is reported, not applied
    assign grant_miss_o = grant_i && (occ_o == '0);

    always_comb begin
        occ_d = occ_o;
        if (land_i) begin
            occ_d = occ_d + OW'(land_cells_i);
        end
        if (grant_i && (occ_o != '0)) begin
            occ_d = occ_d - OW'(1);
        end
    end

    always_comb begin
        dram_d = dram_o;
        if (enq_i) begin
            dram_d = dram_d + DRAM_W'(1);
        end
        if (take_i) begin
            dram_d = dram_d - DRAM_W'(take_cells_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_o  <= '0;
            dram_o <= '0;
        end else begin
            occ_o  <= occ_d;
            dram_o <= dram_d;
        end
    end

endmodule

// File: rtl/hcr_pick.sv
module hcr_pick #(
    parameter int NQ     = 4,
    parameter int BLK    = 8,
    parameter int THRESH = 8,
    parameter int OW     = 5,
    parameter int DRAM_W = 16,
    parameter int QW     = 2,
    parameter int CW     = 4
) (
    input  logic [NQ-1:0][OW-1:0]     occ_i,
    input  logic [NQ-1:0][DRAM_W-1:0] dram_i,
    output logic                      pick_valid_o,
    output logic [QW-1:0]             pick_q_o,
    output logic [CW-1:0]             pick_cells_o
);

    logic [NQ-1:0][OW-1:0] def_w;
    logic [OW-1:0]         best;
    logic [QW-1:0]         best_q;

    // deficit per queue; zero when the queue is not eligible
    for (genvar g = 0; g < NQ; g++) begin : g_def
        assign def_w[g] = ((dram_i[g] != '0) && (occ_i[g] < OW'(THRESH)))
                        ? (OW'(THRESH) - occ_i[g]) : '0;
    end

    // strict compare keeps the lowest index among equal deficits
    always_comb begin
        best   = '0;
        best_q = '0;
        for (int i = 0; i < NQ; i++) begin
            if (def_w[i] > best) begin
                best   = def_w[i];
                best_q = QW'(i);
            end
        end
    end

    assign pick_valid_o = (best != '0);
    assign pick_q_o     = best_q;
    assign pick_cells_o = (dram_i[best_q] >= DRAM_W'(BLK)) ? CW'(BLK)
                                                          : CW'(dram_i[best_q]);

endmodule

// File: rtl/hcr_fsm.sv
module hcr_fsm
    import hcr_pkg::*;
#(
    parameter int BLK      = 8,
    parameter int XFER_LAT = 5,
    parameter int QW       = 2,
    parameter int CW       = 4,
    localparam int SW = (BLK > 1) ? $clog2(BLK) : 1,
    localparam int LW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pick_valid_i,
    input  logic [QW-1:0] pick_q_i,
    input  logic [CW-1:0] pick_cells_i,
    output logic          launch_o,
    output logic          land_o,
    output logic [QW-1:0] land_q_o,
    output logic [CW-1:0] land_cells_o,
    output logic          req_valid_o,
    output logic [QW-1:0] req_queue_o,
    output logic [CW-1:0] req_cells_o
);

    refill_state_e st_q, st_d;
    logic [SW-1:0] slot_q;
    logic [LW-1:0] lat_q;
    logic          slot_tick;

    assign slot_tick = (slot_q == '0);
    assign launch_o  = (st_q == ST_IDLE) && slot_tick && pick_valid_i;
    assign land_o    = (st_q == ST_XFER) && (lat_q == '0);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (slot_tick && pick_valid_i) st_d = ST_XFER;  // launch
            ST_XFER: if (lat_q == '0)               st_d = ST_IDLE;  // land
            default:                                st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // slot timer, transfer timer and request outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q       <= '0;
            lat_q        <= '0;
            req_valid_o  <= 1'b0;
            req_queue_o  <= '0;
            req_cells_o  <= '0;
            land_q_o     <= '0;
            land_cells_o <= '0;
        end else begin
            slot_q      <= (slot_q == SW'(BLK - 1)) ? '0 : slot_q + SW'(1);
            req_valid_o <= launch_o;
            if (launch_o) begin
                req_queue_o  <= pick_q_i;
                req_cells_o  <= pick_cells_i;
                land_q_o     <= pick_q_i;
                land_cells_o <= pick_cells_i;
                lat_q        <= LW'(XFER_LAT - 1);
            end else if ((st_q == ST_XFER) && (lat_q != '0)) begin
                lat_q <= lat_q - LW'(1);
            end
        end
    end

endmodule

// File: rtl/hcache_refill_sched.sv
module hcache_refill_sched #(
    parameter int NQ          = 4,
    parameter int BLK         = 8,
    parameter int HEAD_THRESH = 8,
    parameter int XFER_LAT    = 5,
    parameter int DRAM_W      = 16,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW = $clog2(BLK + 1),
    localparam int OW = $clog2(HEAD_THRESH + BLK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gnt_valid,
    input  logic [QW-1:0] gnt_queue,
    input  logic          enq_valid,
    input  logic [QW-1:0] enq_queue,
    output logic          req_valid,
    output logic [QW-1:0] req_queue,
    output logic [CW-1:0] req_cells,
    output logic          underflow
);

    logic [NQ-1:0][OW-1:0]     occ_w;
    logic [NQ-1:0][DRAM_W-1:0] dram_w;
    logic [NQ-1:0]             miss_w;
    logic                      pick_v;
    logic [QW-1:0]             pick_q;
    logic [CW-1:0]             pick_c;
    logic                      launch;
    logic                      land;
    logic [QW-1:0]             land_q;
    logic [CW-1:0]             land_c;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        hcr_queue_ctr #(.OW(OW), .DRAM_W(DRAM_W), .CW(CW)) u_ctr (
            .clk          (clk),
            .rst          (rst),
            .enq_i        (enq_valid && (enq_queue == QW'(g))),
            .grant_i      (gnt_valid && (gnt_queue == QW'(g))),
            .take_i       (launch && (pick_q == QW'(g))),
            .take_cells_i (pick_c),
            .land_i       (land && (land_q == QW'(g))),
            .land_cells_i (land_c),
            .occ_o        (occ_w[g]),
            .dram_o       (dram_w[g]),
            .grant_miss_o (miss_w[g])
        );
    end

    hcr_pick #(
        .NQ(NQ), .BLK(BLK), .THRESH(HEAD_THRESH), .OW(OW),
        .DRAM_W(DRAM_W), .QW(QW), .CW(CW)
    ) u_pick (
        .occ_i        (occ_w),
        .dram_i       (dram_w),
        .pick_valid_o (pick_v),
        .pick_q_o     (pick_q),
        .pick_cells_o (pick_c)
    );

    hcr_fsm #(.BLK(BLK), .XFER_LAT(XFER_LAT), .QW(QW), .CW(CW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pick_valid_i (pick_v),
        .pick_q_i     (pick_q),
        .pick_cells_i (pick_c),
        .launch_o     (launch),
        .land_o       (land),
        .land_q_o     (land_q),
        .land_cells_o (land_c),
        .req_valid_o  (req_valid),
        .req_queue_o  (req_queue),
        .req_cells_o  (req_cells)
    );

    // sticky empty-grant flag
    always_ff @(posedge clk) begin
        if (rst)          underflow <= 1'b0;
        else if (|miss_w) underflow <= 1'b1;
    end

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
    parameter int BLK = 8,
    parameter int QW  = 2,
    parameter int CW  = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          gnt_valid,
    input logic          enq_valid,
    input logic          req_valid,
    input logic [QW-1:0] req_queue,
    input logic [CW-1:0] req_cells,
    input logic          underflow
);

    logic [15:0] since_q;
    logic        seen_q;
    logic [31:0] enq_sum_q;
    logic [31:0] sent_sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q    <= '0;
            seen_q     <= 1'b0;
            enq_sum_q  <= '0;
            sent_sum_q <= '0;
        end else begin
            if (req_valid) begin
                since_q    <= '0;
                seen_q     <= 1'b1;
                sent_sum_q <= sent_sum_q + 32'(req_cells);
            end else if (since_q != 16'hFFFF) begin
                since_q <= since_q + 16'd1;
            end
            if (enq_valid) enq_sum_q <= enq_sum_q + 32'd1;
        end
    end

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R3
    slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seen_q) |-> (since_q >= 16'(BLK - 1)));

    // R7
    cells_range_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_cells != '0) && (req_cells <= CW'(BLK))));

    // R7
    cell_conserve_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((sent_sum_q + 32'(req_cells)) <= enq_sum_q));

    // R9
    underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow) |-> $past(gnt_valid));

    // R10
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

endmodule

bind hcache_refill_sched hcr_checker #(.BLK(BLK), .QW(QW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gnt_valid (gnt_valid),
    .enq_valid (enq_valid),
    .req_valid (req_valid),
    .req_queue (req_queue),
    .req_cells (req_cells),
    .underflow (underflow)
);

// File: tb/hcache_refill_sched_bench.sv
module hcache_refill_sched_bench;

    localparam int NQ       = 4;
    localparam int BLK      = 8;
    localparam int TH       = 8;
    localparam int XL       = 5;
    localparam int QW       = 2;
    localparam int CW       = 4;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gnt_valid = 1'b0;
    logic [QW-1:0] gnt_queue = '0;
    logic          enq_valid = 1'b0;
    logic [QW-1:0] enq_queue = '0;
    logic          req_valid;
    logic [QW-1:0] req_queue;
    logic [CW-1:0] req_cells;
    logic          underflow;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_occ [NQ];
    int m_dram[NQ];
    int m_slot;
    bit m_busy;
    int m_lat, m_pq, m_pamt;
    bit e_req;
    int e_q, e_cnt;
    bit e_uf;
    bit cmp_on = 0;
    int lfsr = 32'h1ACE5;

    always #(CLK_PER / 2) clk = ~clk;

    hcache_refill_sched #(
        .NQ(NQ), .BLK(BLK), .HEAD_THRESH(TH), .XFER_LAT(XL), .DRAM_W(16)
    ) u_hcache_refill_sched (
        .clk(clk), .rst(rst),
        .gnt_valid(gnt_valid), .gnt_queue(gnt_queue),
        .enq_valid(enq_valid), .enq_queue(enq_queue),
        .req_valid(req_valid), .req_queue(req_queue),
        .req_cells(req_cells), .underflow(underflow)
    );

    function automatic int rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
        return lfsr & 32'h7FFF_FFFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk) begin
        int n_occ[NQ];
        int n_dram[NQ];
        int best, bq, d;
        if (rst) begin
            for (int i = 0; i < NQ; i++) begin m_occ[i] = 0; m_dram[i] = 0; end
            m_slot = 0; m_busy = 0; m_lat = 0; e_req = 0; e_uf = 0;
        end else begin
            n_occ = m_occ;
            n_dram = m_dram;
            e_req = 0;
            if (m_busy) begin
                if (m_lat == 0) begin n_occ[m_pq] += m_pamt; m_busy = 0; end
                else m_lat--;
            end else if (m_slot == 0) begin
                best = 0; bq = 0;
                for (int i = 0; i < NQ; i++) begin
                    d = (m_dram[i] > 0 && m_occ[i] < TH) ? TH - m_occ[i] : 0;
                    if (d > best) begin best = d; bq = i; end
                end
                if (best > 0) begin
                    e_req = 1; e_q = bq;
                    e_cnt = (m_dram[bq] < BLK) ? m_dram[bq] : BLK;
                    n_dram[bq] -= e_cnt;
                    m_busy = 1; m_lat = XL - 1; m_pq = bq; m_pamt = e_cnt;
                end
            end
            if (enq_valid) n_dram[enq_queue]++;
            if (gnt_valid) begin
                if (m_occ[gnt_queue] == 0) e_uf = 1;
                else n_occ[gnt_queue]--;
            end
            m_slot = (m_slot == BLK - 1) ? 0 : m_slot + 1;
            m_occ = n_occ;
            m_dram = n_dram;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk(req_valid == e_req, "R2 R3 R6 R8 req_valid", req_valid, e_req);
            if (req_valid && e_req) begin
                chk(int'(req_queue) == e_q, "R4 R5 req_queue", req_queue, e_q);
                chk(int'(req_cells) == e_cnt, "R2 R7 req_cells", req_cells, e_cnt);
            end
            chk(underflow == e_uf, "R9 R10 underflow", underflow, e_uf);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog cycle=%0d actual=%0d expected=%0d", cyc, cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            gnt_valid = 0; enq_valid = 0;
        end
    endtask

    initial begin
        int q;
        bit any;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(req_valid == 0, "R1 req_valid in reset", req_valid, 0);
        chk(underflow == 0, "R1 underflow in reset", underflow, 0);
        rst = 0;
        cmp_on = 1;

        // R5 tie then R6 threshold: equal backlog on queues 1 and 2, no grants
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            enq_valid = 1; enq_queue = (k % 2 == 0) ? 2'd2 : 2'd1;
            gnt_valid = 0;
        end
        idle(80);

        // R7 partial block on queue 3
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); enq_valid = 1; enq_queue = 2'd3; gnt_valid = 0;
        end
        idle(30);

        // R4 R9 mixed random traffic, grants only to non-empty queues
        for (int k = 0; k < 2500; k++) begin
            @(negedge clk);
            q = rnd() % NQ;
            enq_valid = (rnd() % 3 != 0) && (m_dram[q] < 40);
            enq_queue = QW'(q);
            q = rnd() % NQ;
            gnt_valid = (rnd() % 2 == 0) && (m_occ[q] > 0);
            gnt_queue = QW'(q);
        end

        // drain everything with legal grants
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            enq_valid = 0;
            gnt_valid = 0;
            any = 0;
            for (int i = 0; i < NQ; i++)
                if (m_occ[i] > 0 || m_dram[i] > 0) any = 1;
            if (m_busy) any = 1;
            for (int i = NQ - 1; i >= 0; i--)
                if (m_occ[i] > 0) begin gnt_valid = 1; gnt_queue = QW'(i); end
            if (!any) break;
        end
        idle(2 * BLK);
        chk(req_valid == 0, "R6 no request when drained", req_valid, 0);
        chk(underflow == 0, "R9 no underflow on legal grants", underflow, 0);

        // R9 grant to an empty queue, then R10 stickiness
        @(negedge clk); gnt_valid = 1; gnt_queue = 2'd0;
        @(negedge clk); gnt_valid = 0;
        chk(underflow == 1, "R9 underflow after empty grant", underflow, 1);
        idle(20);
        chk(underflow == 1, "R10 underflow stays set", underflow, 1);

        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule